// File: doc/BRIEF.md
# Ethernet MAC Network Control Register

This block is the main control word of an Ethernet MAC, reached over a simple register bus. It keeps the level enables that the datapath reads every cycle: receive, transmit, local loopback and the management port. It also keeps statistics write access, receive timestamp storage, priority pause reception, back pressure and a low-power-idle request. Other bit positions are commands. Writing a one to a command bit produces a single-clock strobe toward the datapath. These bits keep no state, so they always read back as zero.

Transmit halt needs its own handling. A halt strobe that arrives while no frame is on the wire stops transmission in the next cycle. A halt strobe that arrives during a frame is held as pending until the datapath reports the end of that frame. A new start strobe cancels a pending halt. The block also gates the management interface pins, holds off a flush request while the DMA is busy writing, and allows forced collisions only in half duplex at 10 or 100 Mb/s.

Top module: `eth_net_ctrl_reg`

## Requirements
- R1: After reset every stored bit is zero. A read returns 0x00000000, `mdc_force` is 1 and every other output is 0.
- R2: Only an access with `bus_sel`=1 and `bus_addr`=0x1000 reaches the register. A write to any other address leaves the contents unchanged. A read of any other address, or with `bus_sel`=0, returns zero.
- R3: The stored bits are bit 1 loopback, bit 2 receive enable, bit 3 transmit enable, bit 4 management enable, bit 7 statistics write enable, bit 8 back pressure, bit 15 receive timestamp store, bit 16 priority pause receive and bit 19 low-power idle. A write loads them in the next cycle. They drive `loopback`, `rx_enable`, `tx_enable`, `stat_wr_en`, `rx_ts_store` and `pfc_rx_en`, and they read back in place. All other bits read zero.
- R4: The command bits are bit 5 statistics clear, bit 6 statistics increment, bit 9 start, bit 10 halt, bit 11 pause frame, bit 12 zero-quantum pause frame, bit 17 priority pause frame and bit 18 flush. Writing a one to a command bit pulses its output for exactly the one cycle after the write. Writing a zero has no effect, and these bits read back as zero.
- R5: A halt strobe stops `tx_active` in the next cycle if `frame_busy` is 0 or `frame_end` is 1. Otherwise `tx_halt_pending` is set and `tx_active` stays high. `tx_active` then drops in the cycle after the first `frame_end`.
- R6: A start strobe with transmit enable set raises `tx_active` and clears a pending halt. If start and halt are written together, the halt wins. While transmit enable is 0, `tx_active` and `tx_halt_pending` are held at 0.
- R7: With bit 19 set, `lpi_req` and `tx_path_pause` are 1 whatever the transmit enable bit holds.
- R8: With bit 4 clear, `mdio_oe_allow` is 0 and `mdc_force` is 1. With bit 4 set, they are 1 and 0.
- R9: A flush write produces a `flush_req` pulse only if `dma_writing` is 0 in the write cycle. Otherwise the request is dropped.
- R10: `force_collision` is 1 only while bit 8 is set, `half_duplex` is 1 and `link_slow` (10 or 100 Mb/s) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| frame_busy | input | 1 | A frame is being transmitted |
| frame_end | input | 1 | Last cycle of the frame in progress |
| dma_writing | input | 1 | DMA is moving a stored packet to memory |
| half_duplex | input | 1 | Link is half duplex |
| link_slow | input | 1 | Link runs at 10 or 100 Mb/s |
| rx_enable | output | 1 | Receive enable |
| tx_enable | output | 1 | Transmit enable |
| loopback | output | 1 | Local loopback |
| mdio_oe_allow | output | 1 | Management data output enable permitted |
| mdc_force | output | 1 | Management clock forced to a driven low |
| stat_wr_en | output | 1 | Statistics counters writable |
| stat_clear | output | 1 | Statistics clear strobe |
| stat_incr | output | 1 | Statistics increment strobe |
| force_collision | output | 1 | Force collisions on received frames |
| rx_ts_store | output | 1 | Replace receive CRC with timestamp |
| pfc_rx_en | output | 1 | Priority pause reception enable |
| lpi_req | output | 1 | Send low-power idle |
| tx_path_pause | output | 1 | Pause toward the transmit datapath |
| tx_start | output | 1 | Start-transmit strobe |
| tx_active | output | 1 | Transmission running |
| tx_halt_pending | output | 1 | Halt waiting for frame end |
| tx_pause_req | output | 1 | Pause frame strobe |
| tx_zq_pause_req | output | 1 | Zero-quantum pause frame strobe |
| pfc_pause_req | output | 1 | Priority pause frame strobe |
| flush_req | output | 1 | Flush next packet strobe |

## Verification
The bench targets these corner cases:

- Halts that land on an idle transmitter, inside a frame, and on the frame's final cycle. A design that stopped at once would drop `tx_active` mid-frame. One that ignored `frame_end` would leave it stuck high.
- Start and halt written in one word, and a start issued while a halt is pending. A wrong priority would leave transmission running after a combined write, or halt it after a restart.
- Flush writes made while `dma_writing` is high. A design that misses this gate would emit a spurious flush.
- Writes to nearby addresses. A design that skips full address decode would corrupt the register.
- Command bits read back after a write. A design that stored them would return nonzero values.

// File: rtl/eth_ncr_pkg.sv
`timescale 1ns/1ps
package eth_ncr_pkg;
  localparam int unsigned NCR_W = 32;

  // stored level bits
  localparam int unsigned B_LBL    = 1;
  localparam int unsigned B_RXEN   = 2;
  localparam int unsigned B_TXEN   = 3;
  localparam int unsigned B_MPE    = 4;
  localparam int unsigned B_WESTAT = 7;
  localparam int unsigned B_BP     = 8;
  localparam int unsigned B_SRTSM  = 15;
  localparam int unsigned B_PFCRX  = 16;
  localparam int unsigned B_LPI    = 19;

  // write-one command bits
  localparam int unsigned B_CLR    = 5;
  localparam int unsigned B_INC    = 6;
  localparam int unsigned B_START  = 9;
  localparam int unsigned B_HALT   = 10;
  localparam int unsigned B_PAUSE  = 11;
  localparam int unsigned B_ZQ     = 12;
  localparam int unsigned B_PFCTX  = 17;
  localparam int unsigned B_FLUSH  = 18;

  localparam logic [NCR_W-1:0] LVL_MASK =
      (NCR_W'(1) << B_LBL)    | (NCR_W'(1) << B_RXEN)  | (NCR_W'(1) << B_TXEN) |
      (NCR_W'(1) << B_MPE)    | (NCR_W'(1) << B_WESTAT)| (NCR_W'(1) << B_BP)   |
      (NCR_W'(1) << B_SRTSM)  | (NCR_W'(1) << B_PFCRX) | (NCR_W'(1) << B_LPI);

  typedef struct packed {
    logic lpi;
    logic pfc_rx;
    logic srtsm;
    logic bp;
    logic westat;
    logic mpe;
    logic txen;
    logic rxen;
    logic lbl;
  } ncr_lvl_t;

  typedef struct packed {
    logic flush;
    logic pfc_pause;
    logic zq_pause;
    logic pause;
    logic halt;
    logic start;
    logic inc_stat;
    logic clr_stat;
  } ncr_cmd_t;
endpackage

// File: rtl/eth_ncr_rst_sync.sv
`timescale 1ns/1ps
module eth_ncr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/eth_ncr_regs.sv
`timescale 1ns/1ps
module eth_ncr_regs
  import eth_ncr_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NCR_W-1:0]  bus_wdata,
  output logic [NCR_W-1:0]  bus_rdata,
  output logic              wr_hit,
  output ncr_lvl_t          lvl
);
  logic             addr_hit;
  logic [NCR_W-1:0] word_q;
  logic [NCR_W-1:0] word_d;

  assign addr_hit = bus_sel && (bus_addr == REG_ADDR);
  assign wr_hit   = addr_hit && bus_wr;

  always_comb begin
    word_d = word_q;
    if (wr_hit) word_d = bus_wdata & LVL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign bus_rdata = addr_hit ? word_q : '0;

  always_comb begin
    lvl.lbl    = word_q[B_LBL];
    lvl.rxen   = word_q[B_RXEN];
    lvl.txen   = word_q[B_TXEN];
    lvl.mpe    = word_q[B_MPE];
    lvl.westat = word_q[B_WESTAT];
    lvl.bp     = word_q[B_BP];
    lvl.srtsm  = word_q[B_SRTSM];
    lvl.pfc_rx = word_q[B_PFCRX];
    lvl.lpi    = word_q[B_LPI];
  end

  // R3
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (!addr_hit || bus_rdata == ($past(bus_wdata) & LVL_MASK)));

  // R2
  foreign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr != REG_ADDR) |=> $stable(word_q));
endmodule

// File: rtl/eth_ncr_cmd.sv
`timescale 1ns/1ps
module eth_ncr_cmd
  import eth_ncr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_hit,
  input  ncr_cmd_t cmd_wr,
  input  logic     dma_writing,
  output ncr_cmd_t stb
);
  ncr_cmd_t stb_d;

  always_comb begin
    stb_d = '0;
    if (wr_hit) begin
      stb_d       = cmd_wr;
      stb_d.flush = cmd_wr.flush && !dma_writing;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= '0;
    else        stb <= stb_d;
  end

  // R4
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pause |-> $past(wr_hit && cmd_wr.pause));

  // R4
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> (stb == '0));

  // R9
  flush_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.flush |-> $past(!dma_writing));
endmodule

// File: rtl/eth_ncr_tx_seq.sv
`timescale 1ns/1ps
module eth_ncr_tx_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic start_stb,
  input  logic halt_stb,
  input  logic frame_busy,
  input  logic frame_end,
  output logic tx_active,
  output logic halt_pending
);
  logic act_d;
  logic pend_d;

  always_comb begin
    act_d  = tx_active;
    pend_d = halt_pending;
    if (!tx_en) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end else if (halt_stb) begin
      if (!frame_busy || frame_end) begin
        act_d  = 1'b0;
        pend_d = 1'b0;
      end else begin
        pend_d = tx_active;
      end
    end else if (start_stb) begin
      act_d  = 1'b1;
      pend_d = 1'b0;
    end else if (halt_pending && frame_end) begin
      act_d  = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_active    <= 1'b0;
      halt_pending <= 1'b0;
    end else begin
      tx_active    <= act_d;
      halt_pending <= pend_d;
    end
  end

  // R5
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> $past(!tx_en || halt_stb || (halt_pending && frame_end)));

  // R5
  pend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && halt_pending && frame_end && !start_stb) |=> (!tx_active && !halt_pending));

  // R6
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && start_stb && !halt_stb) |=> (tx_active && !halt_pending));

  // R6
  txen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!tx_active && !halt_pending));
endmodule

// File: rtl/eth_net_ctrl_reg.sv
`timescale 1ns/1ps
module eth_net_ctrl_reg
  import eth_ncr_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 16'h1000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_busy,
  input  logic              frame_end,
  input  logic              dma_writing,
  input  logic              half_duplex,
  input  logic              link_slow,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic              loopback,
  output logic              mdio_oe_allow,
  output logic              mdc_force,
  output logic              stat_wr_en,
  output logic              stat_clear,
  output logic              stat_incr,
  output logic              force_collision,
  output logic              rx_ts_store,
  output logic              pfc_rx_en,
  output logic              lpi_req,
  output logic              tx_path_pause,
  output logic              tx_start,
  output logic              tx_active,
  output logic              tx_halt_pending,
  output logic              tx_pause_req,
  output logic              tx_zq_pause_req,
  output logic              pfc_pause_req,
  output logic              flush_req
);
  logic     rst_sync_n;
  logic     wr_hit;
  ncr_lvl_t lvl;
  ncr_cmd_t cmd_wr;
  ncr_cmd_t stb;

  eth_ncr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eth_ncr_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_hit    (wr_hit),
    .lvl       (lvl)
  );

  always_comb begin
    cmd_wr.clr_stat  = bus_wdata[B_CLR];
    cmd_wr.inc_stat  = bus_wdata[B_INC];
    cmd_wr.start     = bus_wdata[B_START];
    cmd_wr.halt      = bus_wdata[B_HALT];
    cmd_wr.pause     = bus_wdata[B_PAUSE];
    cmd_wr.zq_pause  = bus_wdata[B_ZQ];
    cmd_wr.pfc_pause = bus_wdata[B_PFCTX];
    cmd_wr.flush     = bus_wdata[B_FLUSH];
  end

  eth_ncr_cmd u_cmd (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_hit      (wr_hit),
    .cmd_wr      (cmd_wr),
    .dma_writing (dma_writing),
    .stb         (stb)
  );

  eth_ncr_tx_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tx_en        (lvl.txen),
    .start_stb    (stb.start),
    .halt_stb     (stb.halt),
    .frame_busy   (frame_busy),
    .frame_end    (frame_end),
    .tx_active    (tx_active),
    .halt_pending (tx_halt_pending)
  );

  assign rx_enable       = lvl.rxen;
  assign tx_enable       = lvl.txen;
  assign loopback        = lvl.lbl;
  assign mdio_oe_allow   = lvl.mpe;
  assign mdc_force       = !lvl.mpe;
  assign stat_wr_en      = lvl.westat;
  assign rx_ts_store     = lvl.srtsm;
  assign pfc_rx_en       = lvl.pfc_rx;
  assign lpi_req         = lvl.lpi;
  assign tx_path_pause   = lvl.lpi;
  assign force_collision = lvl.bp && half_duplex && link_slow;
  assign stat_clear      = stb.clr_stat;
  assign stat_incr       = stb.inc_stat;
  assign tx_start        = stb.start;
  assign tx_pause_req    = stb.pause;
  assign tx_zq_pause_req = stb.zq_pause;
  assign pfc_pause_req   = stb.pfc_pause;
  assign flush_req       = stb.flush;

  // R8
  mdio_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_hit && !bus_wdata[B_MPE]) |=> (!mdio_oe_allow && mdc_force));

  // R7
  lpi_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_hit && bus_wdata[B_LPI]) |=> (lpi_req && tx_path_pause));

  // R10
  collision_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_hit && !bus_wdata[B_BP]) |=> !force_collision);
endmodule

// File: tb/eth_net_ctrl_reg_test.sv
`timescale 1ns/1ps
module eth_net_ctrl_reg_test;
  localparam int          CLK_NS = 20;
  localparam logic [15:0] RA     = 16'h1000;
  localparam logic [31:0] LVL    = 32'h0009_819E;
  localparam logic [31:0] CMDM   = 32'h0002_1E60;

  logic clk, rst_n, bus_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic frame_busy, frame_end, dma_writing, half_duplex, link_slow;
  logic rx_enable, tx_enable, loopback, mdio_oe_allow, mdc_force, stat_wr_en;
  logic stat_clear, stat_incr, force_collision, rx_ts_store, pfc_rx_en, lpi_req;
  logic tx_path_pause, tx_start, tx_active, tx_halt_pending, tx_pause_req;
  logic tx_zq_pause_req, pfc_pause_req, flush_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_lvl, m_stb;
  logic m_flush, m_act, m_pend;

  eth_net_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_busy(frame_busy), .frame_end(frame_end), .dma_writing(dma_writing),
    .half_duplex(half_duplex), .link_slow(link_slow),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .loopback(loopback),
    .mdio_oe_allow(mdio_oe_allow), .mdc_force(mdc_force), .stat_wr_en(stat_wr_en),
    .stat_clear(stat_clear), .stat_incr(stat_incr), .force_collision(force_collision),
    .rx_ts_store(rx_ts_store), .pfc_rx_en(pfc_rx_en), .lpi_req(lpi_req),
    .tx_path_pause(tx_path_pause), .tx_start(tx_start), .tx_active(tx_active),
    .tx_halt_pending(tx_halt_pending), .tx_pause_req(tx_pause_req),
    .tx_zq_pause_req(tx_zq_pause_req), .pfc_pause_req(pfc_pause_req),
    .flush_req(flush_req)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    return (bus_sel && bus_addr == RA) ? m_lvl : 32'h0;
  endfunction

  task automatic check_all();
    chk(bus_rdata, exp_rdata(), "R3 readback");
    chk(32'({rx_enable, tx_enable, loopback, stat_wr_en, rx_ts_store, pfc_rx_en}),
        32'({m_lvl[2], m_lvl[3], m_lvl[1], m_lvl[7], m_lvl[15], m_lvl[16]}), "R3 level outputs");
    chk(32'({mdio_oe_allow, mdc_force}), 32'({m_lvl[4], !m_lvl[4]}), "R8 management gating");
    chk(32'({lpi_req, tx_path_pause}), 32'({m_lvl[19], m_lvl[19]}), "R7 low-power idle");
    chk(32'(force_collision), 32'(m_lvl[8] && half_duplex && link_slow), "R10 forced collision");
    chk(32'({tx_start, stat_clear, stat_incr, tx_pause_req, tx_zq_pause_req, pfc_pause_req}),
        32'({m_stb[9], m_stb[5], m_stb[6], m_stb[11], m_stb[12], m_stb[17]}), "R4 strobes");
    chk(32'(flush_req), 32'(m_flush), "R9 flush gating");
    chk(32'({tx_active, tx_halt_pending}), 32'({m_act, m_pend}), "R5 R6 halt sequencing");
  endtask

  task automatic step(input logic s, input logic w, input logic [15:0] a, input logic [31:0] d,
                      input logic bz, input logic fe, input logic dm,
                      input logic hd, input logic sl);
    logic hit, n_act, n_pend;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    frame_busy = bz; frame_end = fe; dma_writing = dm;
    half_duplex = hd; link_slow = sl;
    hit    = s && w && (a == RA);
    n_act  = m_act;
    n_pend = m_pend;
    if (!m_lvl[3]) begin
      n_act = 1'b0; n_pend = 1'b0;
    end else if (m_stb[10]) begin
      if (!bz || fe) begin n_act = 1'b0; n_pend = 1'b0; end
      else n_pend = m_act;
    end else if (m_stb[9]) begin
      n_act = 1'b1; n_pend = 1'b0;
    end else if (m_pend && fe) begin
      n_act = 1'b0; n_pend = 1'b0;
    end
    m_act  = n_act;
    m_pend = n_pend;
    if (hit) m_lvl = d & LVL;
    m_stb   = hit ? (d & CMDM) : 32'h0;
    m_flush = hit && d[18] && !dm;
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [31:0] d, input logic bz, input logic dm);
    step(1'b1, 1'b1, RA, d, bz, 1'b0, dm, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic bz, input logic fe);
    step(1'b1, 1'b0, RA, 32'h0, bz, fe, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 16'h0; bus_wdata = 32'h0;
    frame_busy = 1'b0; frame_end = 1'b0; dma_writing = 1'b0;
    half_duplex = 1'b0; link_slow = 1'b0;
    m_lvl = 32'h0; m_stb = 32'h0; m_flush = 1'b0; m_act = 1'b0; m_pend = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_sel = 1'b1; bus_addr = RA;
    @(negedge clk);
    chk(bus_rdata, 32'h0, "R1 reset readback");
    chk(32'(mdc_force), 32'h1, "R1 reset mdc_force");
    chk(32'({rx_enable, tx_enable, loopback, mdio_oe_allow, stat_wr_en, lpi_req, tx_active,
             tx_start, flush_req, force_collision}), 32'h0, "R1 reset outputs");

    // all ones, DMA busy: flush dropped, halt wins over start
    wr(32'hFFFF_FFFF, 1'b0, 1'b1);
    chk(bus_rdata, LVL, "R3 only stored bits read back");
    chk(32'(flush_req), 32'h0, "R9 flush dropped while DMA writing");
    chk(32'(tx_start), 32'h1, "R4 start strobe");
    idle(1'b0, 1'b0);
    chk(32'(tx_start), 32'h0, "R4 strobe lasts one cycle");
    chk(32'(tx_active), 32'h0, "R6 halt wins over start");

    // R2 address decode
    step(1'b1, 1'b1, 16'h1004, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(1'b0, 1'b0);
    chk(bus_rdata, LVL, "R2 foreign write ignored");
    step(1'b1, 1'b0, 16'h1004, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(bus_rdata, 32'h0, "R2 foreign read is zero");

    // R6 start
    wr(LVL | 32'h200, 1'b0, 1'b0);
    idle(1'b0, 1'b0);
    chk(32'(tx_active), 32'h1, "R6 start raises tx_active");

    // R5 halt during a frame
    wr(LVL | 32'h400, 1'b1, 1'b0);
    idle(1'b1, 1'b0);
    chk(32'({tx_active, tx_halt_pending}), 32'h3, "R5 halt held while busy");
    idle(1'b1, 1'b0);
    chk(32'({tx_active, tx_halt_pending}), 32'h3, "R5 still pending");
    idle(1'b1, 1'b1);
    chk(32'({tx_active, tx_halt_pending}), 32'h0, "R5 stop at frame end");

    // R6 start cancels pending halt
    wr(LVL | 32'h200, 1'b0, 1'b0);
    idle(1'b0, 1'b0);
    wr(LVL | 32'h400, 1'b1, 1'b0);
    idle(1'b1, 1'b0);
    wr(LVL | 32'h200, 1'b1, 1'b0);
    idle(1'b1, 1'b0);
    chk(32'({tx_active, tx_halt_pending}), 32'h2, "R6 start cancels halt");
    idle(1'b1, 1'b1);
    chk(32'(tx_active), 32'h1, "R6 frame end after cancel keeps running");

    // R5 halt when idle
    wr(LVL | 32'h400, 1'b0, 1'b0);
    idle(1'b0, 1'b0);
    chk(32'(tx_active), 32'h0, "R5 idle halt immediate");

    // R7 low-power idle with transmit disabled
    wr(32'h0008_0000, 1'b0, 1'b0);
    chk(32'({lpi_req, tx_path_pause, tx_enable}), 32'h6, "R7 lpi with TXEN clear");

    // R9 flush
    wr(32'h0004_0000, 1'b0, 1'b0);
    chk(32'(flush_req), 32'h1, "R9 flush when DMA idle");
    wr(32'h0004_0000, 1'b0, 1'b1);
    chk(32'(flush_req), 32'h0, "R9 flush while DMA writing");

    // R10 back pressure modes
    wr(32'h0000_0100, 1'b0, 1'b0);
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(32'(force_collision), 32'h1, "R10 half duplex slow");
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(32'(force_collision), 32'h0, "R10 half duplex fast");
    step(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(32'(force_collision), 32'h0, "R10 full duplex slow");

    // R8 management port
    wr(32'h0000_0010, 1'b0, 1'b0);
    chk(32'({mdio_oe_allow, mdc_force}), 32'h2, "R8 enabled");
    wr(32'h0000_0000, 1'b0, 1'b0);
    chk(32'({mdio_oe_allow, mdc_force}), 32'h1, "R8 disabled");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic bz;
      a  = (($urandom % 4) != 0) ? RA : 16'($urandom);
      bz = 1'($urandom);
      step(1'($urandom), 1'($urandom), a, $urandom, bz, bz && (($urandom % 3) == 0),
           1'($urandom), 1'($urandom), 1'($urandom));
    end

    finish_run();
  end
endmodule